// File: doc/BRIEF.md
# Idle Receive Clock Gater

This block sits between a free-running receive clock domain and the MAC. When no frame is arriving, it parks the receive clock toward the MAC at a steady low level to save switching power. When a frame shows up it wakes the clock again. The nibble data and its valid flag go through a single register stage. Because of that stage, the first gated clock edge is the one that launches the delayed valid high, so the MAC always sees one clock edge ahead of the first valid nibble.

After the delayed valid drops, the clock keeps running for a fixed tail of edges and then parks again. If a new frame begins during the tail, the countdown is cancelled and the clock never stops.

Gating only applies when the gating enable bit is set and the link runs at 100 Mb/s. Loopback or the coding-bypass mode forces the clock to run freely.

The clock is gated through a latch that is transparent while the source clock is low. Every gated pulse is therefore a full-width copy of a source clock high phase.

Top module: `rx_clk_gater`

## Requirements
- R1: With gating armed (enable=1, 100 Mb/s=1, loopback=0, bypass=0), `rx_clk_o` shows no rising edge for any source edge once the tail has expired and `rx_dv_i` stays low; the output stays low.
- R2: When `gate_en_i`=0 or `mode_100_i`=0, `rx_clk_o` produces a rising edge on every source clock edge.
- R3: Starting from a parked clock, the first rising edge of `rx_clk_o` is the source edge that launches `rx_dv_o` high. Exactly one gated edge therefore comes before the first gated edge at which `rx_dv_o` is sampled high.
- R4: After the source edge at which `rx_dv_o` falls, exactly TAIL_CYCLES (default 64) further gated rising edges occur, and then the clock parks.
- R5: When `loopback_i`=1, `rx_clk_o` runs on every source edge regardless of the other controls.
- R6: When `bypass_i`=1, `rx_clk_o` runs on every source edge regardless of the other controls.
- R7: `rx_dv_o` and `rxd_o` equal `rx_dv_i` and `rxd_i` as sampled on the previous source clock edge.
- R8: A rise of `rx_dv_i` during the tail cancels the countdown with no missing gated edge. A full TAIL_CYCLES tail follows the end of the new frame.
- R9: Synchronous active-high reset clears `rx_dv_o`, `rxd_o` and any pending tail, so that an armed gater with `rx_dv_i` low is parked right after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running receive clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rx_dv_i | input | 1 | Receive data valid from the line side |
| rxd_i | input | DATA_W | Receive nibble from the line side |
| gate_en_i | input | 1 | Gating enable control bit |
| mode_100_i | input | 1 | 1 when the link runs at 100 Mb/s |
| loopback_i | input | 1 | Loopback active; forces the clock on |
| bypass_i | input | 1 | Coding-bypass mode active; forces the clock on |
| rx_clk_o | output | 1 | Gated receive clock toward the MAC |
| rxd_o | output | DATA_W | Receive nibble delayed one clock |
| rx_dv_o | output | 1 | Receive data valid delayed one clock |

## Verification
The bench counts gated clock edges around every frame. If the wake edge came one cycle late, the MAC would see valid data with no lead edge. If it came one cycle early, a stray extra edge would appear, and an off-by-one tail counter would give 63 or 65 tail edges.

Two gap-boundary cases are run. A new frame one cycle before the tail expires must keep the clock running without a hole. A new frame one cycle after expiry must produce a fresh single lead edge.

Frames are restarted mid-tail, which catches a gater that drops edges or fails to reload the tail. Each override is toggled while a tail is pending, which exposes a counter that resumes stale counting after the override clears.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

    localparam int unsigned NIBBLE_W     = 4;
    localparam int unsigned TAIL_DEFAULT = 64;

    typedef struct packed {
        logic gate_en;
        logic mode_100;
        logic loopback;
        logic bypass;
    } gate_ctrl_t;

    typedef enum logic [1:0] {
        WAKE_FREE   = 2'd0,
        WAKE_FRAME  = 2'd1,
        WAKE_TAIL   = 2'd2,
        WAKE_PARKED = 2'd3
    } wake_reason_e;

    function automatic logic gating_armed(gate_ctrl_t c);
        return c.gate_en && c.mode_100 && !c.loopback && !c.bypass;
    endfunction

endpackage

// File: rtl/rcg_pipe.sv
module rcg_pipe #(
    parameter int unsigned DATA_W = rcg_pkg::NIBBLE_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              dv_i,
    input  logic [DATA_W-1:0] d_i,
    output logic              dv_o,
    output logic [DATA_W-1:0] d_o
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } beat_t;

    beat_t stage_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage_q <= '0;
        end else begin
            stage_q.valid <= dv_i;
            stage_q.data  <= d_i;
        end
    end

    assign dv_o = stage_q.valid;
    assign d_o  = stage_q.data;
endmodule

// File: rtl/rcg_tail.sv
module rcg_tail
    import rcg_pkg::*;
#(
    parameter int unsigned TAIL_CYCLES = TAIL_DEFAULT
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic armed_i,
    input  logic dv_in_i,
    input  logic dv_out_i,
    output logic wake_o
);
    localparam int unsigned CNT_W = $clog2(TAIL_CYCLES + 1);
    localparam logic [CNT_W-1:0] TAIL_LOAD = CNT_W'(TAIL_CYCLES);

    logic [CNT_W-1:0] left_q;
    wake_reason_e     reason;

    // Countdown of gated edges still owed after the delayed valid fell.
    always_ff @(posedge clk_i) begin
        if (rst_i || !armed_i) begin
            left_q <= '0;
        end else if (dv_in_i) begin
            left_q <= '0;
        end else if (dv_out_i) begin
            left_q <= TAIL_LOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    always_comb begin
        if (!armed_i) begin
            reason = WAKE_FREE;
        end else if (dv_in_i || dv_out_i) begin
            reason = WAKE_FRAME;
        end else if (left_q != '0) begin
            reason = WAKE_TAIL;
        end else begin
            reason = WAKE_PARKED;
        end
    end

    assign wake_o = (reason != WAKE_PARKED);
endmodule

// File: rtl/rcg_gate.sv
module rcg_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);
    logic en_lat;

    // Transparent while the source clock is low, so the enable cannot
    // change during a high phase and every pulse is full width.
    always_latch begin
        if (!clk_i) begin
            en_lat <= en_i;
        end
    end

    assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/rx_clk_gater.sv
module rx_clk_gater
    import rcg_pkg::*;
#(
    parameter int unsigned DATA_W      = NIBBLE_W,
    parameter int unsigned TAIL_CYCLES = TAIL_DEFAULT
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rx_dv_i,
    input  logic [DATA_W-1:0] rxd_i,
    input  logic              gate_en_i,
    input  logic              mode_100_i,
    input  logic              loopback_i,
    input  logic              bypass_i,
    output logic              rx_clk_o,
    output logic [DATA_W-1:0] rxd_o,
    output logic              rx_dv_o
);
    gate_ctrl_t ctrl;
    logic       armed;
    logic       wake;

    assign ctrl  = '{gate_en: gate_en_i, mode_100: mode_100_i,
                     loopback: loopback_i, bypass: bypass_i};
    assign armed = gating_armed(ctrl);

    rcg_pipe #(.DATA_W(DATA_W)) u_pipe (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .dv_i  (rx_dv_i),
        .d_i   (rxd_i),
        .dv_o  (rx_dv_o),
        .d_o   (rxd_o)
    );

    rcg_tail #(.TAIL_CYCLES(TAIL_CYCLES)) u_tail (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .armed_i  (armed),
        .dv_in_i  (rx_dv_i),
        .dv_out_i (rx_dv_o),
        .wake_o   (wake)
    );

    rcg_gate u_gate (
        .clk_i  (clk_i),
        .en_i   (wake),
        .gclk_o (rx_clk_o)
    );
endmodule

// File: rtl/rcg_checker.sv
module rcg_checker #(
    parameter int unsigned DATA_W      = 4,
    parameter int unsigned TAIL_CYCLES = 64
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              rx_dv_i,
    input logic [DATA_W-1:0] rxd_i,
    input logic              gate_en_i,
    input logic              mode_100_i,
    input logic              loopback_i,
    input logic              bypass_i,
    input logic              rx_clk_o,
    input logic [DATA_W-1:0] rxd_o,
    input logic              rx_dv_o
);
    logic        armed;
    int unsigned since_fall;

    assign armed = gate_en_i && mode_100_i && !loopback_i && !bypass_i;

    // Edges since the delayed valid fell; saturates beyond the tail.
    always_ff @(negedge clk_i) begin
        if (rst_i) begin
            since_fall <= TAIL_CYCLES + 1;
        end else if (rx_dv_o) begin
            since_fall <= 0;
        end else if (!armed) begin
            since_fall <= TAIL_CYCLES + 1;
        end else if (since_fall <= TAIL_CYCLES) begin
            since_fall <= since_fall + 1;
        end
    end

    assert_idle_parked_R1: assert property (@(negedge clk_i) disable iff (rst_i)
        (armed && !rx_dv_o && since_fall > TAIL_CYCLES) |-> !rx_clk_o);

    assert_free_run_R2: assert property (@(negedge clk_i) disable iff (rst_i)
        (!gate_en_i || !mode_100_i) |-> rx_clk_o);

    assert_wake_lead_R3: assert property (@(negedge clk_i) disable iff (rst_i)
        $rose(rx_dv_o) |-> rx_clk_o);

    assert_tail_edges_R4: assert property (@(negedge clk_i) disable iff (rst_i)
        (armed && !rx_dv_o && since_fall <= TAIL_CYCLES) |-> rx_clk_o);

    assert_loopback_run_R5: assert property (@(negedge clk_i) disable iff (rst_i)
        loopback_i |-> rx_clk_o);

    assert_bypass_run_R6: assert property (@(negedge clk_i) disable iff (rst_i)
        bypass_i |-> rx_clk_o);

    assert_one_stage_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> (rx_dv_o == $past(rx_dv_i) && rxd_o == $past(rxd_i)));
endmodule

bind rx_clk_gater rcg_checker #(.DATA_W(DATA_W), .TAIL_CYCLES(TAIL_CYCLES)) u_rcg_checker (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .rx_dv_i    (rx_dv_i),
    .rxd_i      (rxd_i),
    .gate_en_i  (gate_en_i),
    .mode_100_i (mode_100_i),
    .loopback_i (loopback_i),
    .bypass_i   (bypass_i),
    .rx_clk_o   (rx_clk_o),
    .rxd_o      (rxd_o),
    .rx_dv_o    (rx_dv_o)
);

// File: tb/tb_rx_clk_gater.sv
`timescale 1ns/1ps
module tb_rx_clk_gater;
    localparam int TAIL = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dv = 1'b0;
    logic [3:0] rxd = 4'h0;
    logic       gate_en = 1'b1;
    logic       mode100 = 1'b1;
    logic       lb = 1'b0;
    logic       byp = 1'b0;
    logic       gclk;
    logic [3:0] rxd_o;
    logic       dv_o;

    int  n_checks = 0;
    int  n_fail = 0;
    int  pulses = 0;
    int  gtotal = 0;
    int  g_fall = 0;
    int  edge_idx = 0;
    int  last_hi = 0;
    bit  tail_valid = 1'b0;
    bit  m_dvo = 1'b0;
    bit  done = 1'b0;
    string tag = "R1";

    always #10 clk = ~clk;

    rx_clk_gater #(.DATA_W(4), .TAIL_CYCLES(TAIL)) dut (
        .clk_i(clk), .rst_i(rst), .rx_dv_i(dv), .rxd_i(rxd),
        .gate_en_i(gate_en), .mode_100_i(mode100), .loopback_i(lb),
        .bypass_i(byp), .rx_clk_o(gclk), .rxd_o(rxd_o), .rx_dv_o(dv_o)
    );

    always @(posedge gclk) begin
        pulses = pulses + 1;
        gtotal = gtotal + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference, evaluated after each source edge.
    always @(negedge clk) begin
        if (!done) begin
            if (rst) begin
                m_dvo = 1'b0;
                tail_valid = 1'b0;
            end else begin
                bit act;
                bit exp_p;
                act = gate_en && mode100 && !lb && !byp;
                if (!act) tail_valid = 1'b0;
                else if (m_dvo) begin
                    last_hi = edge_idx;
                    tail_valid = 1'b1;
                end
                exp_p = !act || dv || (tail_valid && (edge_idx - last_hi) <= TAIL);
                check(pulses == (exp_p ? 1 : 0), tag, pulses, exp_p ? 1 : 0);
                check(dv_o == dv, "R7 valid", dv_o, dv);
                check(rxd_o == rxd, "R7 data", rxd_o, rxd);
                m_dvo = dv;
            end
            edge_idx++;
            pulses = 0;
        end
    end

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic idle(input int n);
        dv = 1'b0;
        for (int i = 0; i < n; i++) tick();
    endtask

    // Frame of len nibbles; if lead_chk the clock must be parked beforehand.
    task automatic frame(input int len, input bit lead_chk);
        int g0;
        g0 = gtotal;
        dv = 1'b1;
        rxd = 4'(len);
        tick();
        if (lead_chk)
            check(gtotal - g0 == 1 && dv_o == 1'b1, "R3 lead edge", gtotal - g0, 1);
        for (int i = 1; i < len; i++) begin
            rxd = 4'(i * 5 + len);
            tick();
        end
        dv = 1'b0;
        tick();
        g_fall = gtotal;
    endtask

    task automatic tail_chk(input string req);
        check(gtotal - g_fall == TAIL, req, gtotal - g_fall, TAIL);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) tick();
        rst = 1'b0;
        tick();
        tag = "R9";
        check(dv_o == 1'b0 && rxd_o == 4'h0, "R9 reset outputs", dv_o, 0);
        begin
            int g0;
            g0 = gtotal;
            tick(); tick();
            check(gtotal == g0, "R9 parked after reset", gtotal - g0, 0);
        end
        tag = "R1";
        idle(8);
        tag = "R4";
        frame(20, 1'b1);
        idle(TAIL + 10);
        tail_chk("R4 tail count");
        tag = "R1";
        begin
            int g0;
            g0 = gtotal;
            idle(10);
            check(gtotal == g0, "R1 idle parked", gtotal - g0, 0);
        end
        tag = "R8";
        frame(10, 1'b1);
        idle(30);
        frame(5, 1'b0);
        idle(TAIL + 5);
        tail_chk("R8 fresh tail");
        tag = "R8";
        frame(3, 1'b1);
        idle(TAIL - 1);
        frame(4, 1'b0);
        idle(TAIL + 3);
        tail_chk("R8 late restart tail");
        tag = "R3";
        frame(2, 1'b1);
        idle(TAIL + 1);
        frame(6, 1'b1);
        idle(TAIL + 4);
        tag = "R4";
        frame(1, 1'b1);
        frame(1, 1'b0);
        idle(TAIL + 4);
        tail_chk("R4 back-to-back tail");
        tag = "R2";
        gate_en = 1'b0;
        frame(7, 1'b0);
        idle(20);
        mode100 = 1'b0;
        gate_en = 1'b1;
        idle(10);
        frame(4, 1'b0);
        idle(10);
        mode100 = 1'b1;
        tag = "R1";
        idle(TAIL + 3);
        tag = "R5";
        frame(5, 1'b1);
        idle(10);
        lb = 1'b1;
        idle(80);
        frame(6, 1'b0);
        idle(5);
        lb = 1'b0;
        tag = "R1";
        idle(TAIL + 3);
        tag = "R6";
        frame(4, 1'b1);
        idle(20);
        byp = 1'b1;
        idle(30);
        frame(3, 1'b0);
        idle(30);
        byp = 1'b0;
        tag = "R1";
        idle(20);
        tag = "R3";
        frame(9, 1'b1);
        idle(TAIL + 2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule